// File: doc/BRIEF.md
# Password-Protected Watchdog Timer

This block is a watchdog timer on a simple register bus with address, write strobe, write data and read data. Software may change the control register only through a two-write unlock. The first control write carries a first password in the password field. The next control write carries a second password together with the new enable, lock, divider and reload settings. Start, stop and service (kick) all use this same pair of writes. A control write that arrives out of order, or that carries the wrong password, drops the unlock back to idle and changes nothing.

While enabled, a 16-bit down-counter decrements once per prescaled tick. Four divider codes select the tick rate. When the count runs out, the block raises a one-cycle reset-request pulse and sets a sticky flag. The flag records that the last reset came from the watchdog, and software clears it by writing 1. A status register reports whether the counter is running. A lock setting stops software from disabling a running watchdog until the next hardware reset. The bus is a plain register port with no back-pressure: every write completes in the cycle it is presented, and reads return combinationally.

Top module: `wdt_timer`

## Requirements
- R1: After reset, the control readback is 0, the status readback is 0 and the reset request is low.
- R2: A control write is accepted only as the second of a pair. A write whose password field (bits 23:16) is the second password 8'hDC, sent while the unlock is idle, changes nothing.
- R3: In the armed step, a control write whose password is anything other than 8'hDC (this includes a repeated 8'hBE) returns the unlock to idle and changes nothing. A following 8'hDC write is also rejected.
- R4: A write with password 8'hBE followed by a write with 8'hDC applies the configuration. The enable bit is bit 31, lock is bit 30, the divider is bits 25:24 and the reload is bits 15:0. Control readback (offset 0x0) returns these fields in the same positions, with the password field reading 0.
- R5: With enable set, the reset request first goes high exactly P*max(R,1) clock edges after the applying edge. R is the reload and P = 2^DIV_SHIFT[code]; the defaults give 1, 64, 4096 and 0x40000 clocks per tick for codes 0 to 3.
- R6: The reset request stays high for exactly one cycle per expiry. The counter then waits at zero until it is reloaded.
- R7: Status bit 0 (offset 0x8) is set by an expiry and stays set. Writing 1 to bit 0 of the status register clears it, and writing 0 leaves it set.
- R8: A service, which is another unlock pair with enable set, reloads the counter and clears the prescaler, so expiry is measured again from the service write.
- R9: An unlock pair with enable clear stops the counter: status bit 31 reads 0 and no reset request follows.
- R10: Once lock is set on an enabled watchdog, an unlock pair with enable clear does not stop it (status bit 31 stays 1). Only a hardware reset clears lock.
- R11: Status bit 31 reads 1 exactly while the watchdog is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Byte address: 0x0 control, 0x8 status |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| wdt_rst_req | output | 1 | One-cycle reset-request pulse on expiry |

## Verification
The hardest case to reach from the ports is expiry at the slow divider codes: with default parameters, code 3 and the largest reload would take about 2^34 clocks. The bench therefore builds the block with divider shifts of 0, 1, 2 and 3. With these it sweeps every divider code against several reloads, including 0 and 1, and checks the expiry edge against P*max(R,1) computed in the bench. The locked state is reached only by a correct unlock pair with both enable and lock set. The bench then tries to disable it and finally releases it with a hardware reset.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int RLD_W = 16;
  localparam logic [7:0] PW_FIRST = 8'hBE;
  localparam logic [7:0] PW_SECOND = 8'hDC;
  localparam int CTRL_OFS = 0;
  localparam int STAT_OFS = 8;
  localparam int BIT_EN = 31;
  localparam int BIT_LOCK = 30;
  localparam int DIV_HI = 25;
  localparam int DIV_LO = 24;
  localparam int PW_HI = 23;
  localparam int PW_LO = 16;

  typedef struct packed {
    logic             en;
    logic             lock;
    logic [1:0]       div;
    logic [RLD_W-1:0] reload;
  } wdt_cfg_t;

  typedef enum logic {ST_IDLE, ST_ARMED} unlock_st_e;
endpackage

// File: rtl/wdt_unlock.sv
module wdt_unlock
  import wdt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctrl_wr,
  input  logic [7:0] pw,
  output logic       apply
);
  unlock_st_e st_q, st_d;

  always_comb begin
    st_d  = st_q;
    apply = 1'b0;
    if (ctrl_wr) begin
      case (st_q)
        ST_IDLE:  st_d = (pw == PW_FIRST) ? ST_ARMED : ST_IDLE;
        ST_ARMED: begin
          st_d  = ST_IDLE;
          apply = (pw == PW_SECOND);
        end
        default:  st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  // R3: any second-step write leaves the sequence idle
  assert_second_step_ends_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && st_q == ST_ARMED) |=> (st_q == ST_IDLE));
endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int DIV_SHIFT [4] = '{0, 6, 12, 18}
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       clr,
  input  logic [1:0] div,
  output logic       tick
);
  function automatic int max_shift();
    int m = 1;
    for (int i = 0; i < 4; i++) if (DIV_SHIFT[i] > m) m = DIV_SHIFT[i];
    return m;
  endfunction
  localparam int PRE_W = max_shift();

  logic [PRE_W-1:0] lim [4];
  logic [PRE_W-1:0] pre_q;

  for (genvar g = 0; g < 4; g++) begin : g_lim
    assign lim[g] = PRE_W'((64'd1 << DIV_SHIFT[g]) - 64'd1);
  end

  assign tick = run && (pre_q == lim[div]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            pre_q <= '0;
    else if (!run || clr)  pre_q <= '0;
    else if (tick)         pre_q <= '0;
    else                   pre_q <= pre_q + 1'b1;
  end

  // R5: the prescaler never runs past the terminal count of its code
  assert_pre_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !clr && $stable(div)) |=> (pre_q <= lim[div]));
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
  import wdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             load,
  input  logic [RLD_W-1:0] load_val,
  input  logic             tick,
  output logic             fire
);
  logic [RLD_W-1:0] cnt_q;
  logic             done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
      fire   <= 1'b0;
    end else begin
      fire <= 1'b0;
      if (load) begin
        cnt_q  <= load_val;
        done_q <= 1'b0;
      end else if (en && tick && !done_q) begin
        if (cnt_q <= RLD_W'(1)) begin
          cnt_q  <= '0;
          done_q <= 1'b1;
          fire   <= 1'b1;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  // R6: the request is a single-cycle pulse
  assert_single_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !fire);
  // R9: no request unless the counter was enabled
  assert_fire_needs_en_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> $past(en));
endmodule

// File: rtl/wdt_timer.sv
module wdt_timer
  import wdt_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DIV_SHIFT [4] = '{0, 6, 12, 18}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              wdt_rst_req
);
  wdt_cfg_t cfg_q, cfg_in, cfg_new;
  logic     ctrl_wr, stat_wr, apply, load, tick, fire, flag_q;
  logic     unused_bits;

  assign ctrl_wr = bus_wr && (bus_addr == ADDR_W'(CTRL_OFS));
  assign stat_wr = bus_wr && (bus_addr == ADDR_W'(STAT_OFS));
  assign unused_bits = ^bus_wdata[29:26];

  assign cfg_in.en     = bus_wdata[BIT_EN];
  assign cfg_in.lock   = bus_wdata[BIT_LOCK];
  assign cfg_in.div    = bus_wdata[DIV_HI:DIV_LO];
  assign cfg_in.reload = bus_wdata[RLD_W-1:0];

  always_comb begin
    cfg_new      = cfg_in;
    cfg_new.en   = cfg_in.en | (cfg_q.lock & cfg_q.en);
    cfg_new.lock = cfg_q.lock | cfg_in.lock;
  end

  assign load = apply && cfg_new.en;

  wdt_unlock u_unlock (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr),
    .pw(bus_wdata[PW_HI:PW_LO]), .apply(apply)
  );

  wdt_prescaler #(.DIV_SHIFT(DIV_SHIFT)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(cfg_q.en), .clr(load),
    .div(cfg_q.div), .tick(tick)
  );

  wdt_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .en(cfg_q.en), .load(load),
    .load_val(cfg_new.reload), .tick(tick), .fire(fire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (apply) cfg_q <= cfg_new;
      if (fire)                         flag_q <= 1'b1;
      else if (stat_wr && bus_wdata[0]) flag_q <= 1'b0;
    end
  end

  assign wdt_rst_req = fire;

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(CTRL_OFS)) begin
      bus_rdata[BIT_EN]        = cfg_q.en;
      bus_rdata[BIT_LOCK]      = cfg_q.lock;
      bus_rdata[DIV_HI:DIV_LO] = cfg_q.div;
      bus_rdata[RLD_W-1:0]     = cfg_q.reload;
    end else if (bus_addr == ADDR_W'(STAT_OFS)) begin
      bus_rdata[31] = cfg_q.en;
      bus_rdata[0]  = flag_q;
    end
  end

  // R2: configuration only moves on a completed unlock pair
  assert_cfg_needs_unlock_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q != $past(cfg_q)) |-> $past(apply));
  // R7: an expiry leaves the sticky flag set
  assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst_req |=> flag_q);
  // R10: a locked running watchdog stays running
  assert_lock_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q.lock && cfg_q.en) |=> (cfg_q.lock && cfg_q.en));
endmodule

// File: tb/wdt_timer_bench.sv
module wdt_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        wdt_rst_req;

  int n_run = 0, n_fail = 0, cyc = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  wdt_timer #(.ADDR_W(4), .DIV_SHIFT('{0, 1, 2, 3})) u_wdt_timer (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wdt_rst_req(wdt_rst_req)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] cw(bit en, bit lk, logic [1:0] dv, logic [7:0] pw, logic [15:0] rl);
    return {en, lk, 4'b0, dv, pw, rl};
  endfunction

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wr = 1'b0; #1 d = bus_rdata;
  endtask

  task automatic unlock_pair(input bit en, input bit lk, input logic [1:0] dv, input logic [15:0] rl);
    wr(4'h0, cw(0, 0, 0, 8'hBE, 0));
    wr(4'h0, cw(en, lk, dv, 8'hDC, rl));
  endtask

  task automatic measure(input int limit, output int n);
    n = 0;
    for (int i = 1; i <= limit; i++) begin
      @(negedge clk);
      if (wdt_rst_req) begin n = i; break; end
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !finished) begin
      finished = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog timeout actual=%0d expected=<100000", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int n, exp_n;
    logic [15:0] rls [6];
    rls = '{16'd0, 16'd1, 16'd2, 16'd3, 16'd5, 16'd17};
    do_reset();

    // R1 reset state
    rd(4'h0, d); chk(d == 0, "R1 ctrl after reset", d, 0);
    rd(4'h8, d); chk(d == 0, "R1 status after reset", d, 0);
    chk(!wdt_rst_req, "R1 request low", wdt_rst_req, 0);

    // R2 second password alone
    wr(4'h0, cw(1, 0, 0, 8'hDC, 16'd4));
    rd(4'h8, d); chk(d[31] == 0, "R2 lone second write", d[31], 0);
    rd(4'h0, d); chk(d == 0, "R2 ctrl unchanged", d, 0);

    // R3 wrong password in armed step, then lone second
    wr(4'h0, cw(0, 0, 0, 8'hBE, 0));
    wr(4'h0, cw(1, 0, 0, 8'h12, 16'd4));
    rd(4'h8, d); chk(d[31] == 0, "R3 wrong password", d[31], 0);
    wr(4'h0, cw(1, 0, 0, 8'hDC, 16'd4));
    rd(4'h8, d); chk(d[31] == 0, "R3 second after abort", d[31], 0);
    // R3 repeated first password
    wr(4'h0, cw(0, 0, 0, 8'hBE, 0));
    wr(4'h0, cw(0, 0, 0, 8'hBE, 0));
    wr(4'h0, cw(1, 0, 0, 8'hDC, 16'd4));
    rd(4'h8, d); chk(d[31] == 0, "R3 repeated first", d[31], 0);

    // R4 / R11 configuration applied and read back
    unlock_pair(1, 0, 2'd2, 16'h1234);
    rd(4'h0, d); chk(d == cw(1, 0, 2'd2, 8'h00, 16'h1234), "R4 ctrl readback", d, cw(1, 0, 2'd2, 8'h00, 16'h1234));
    rd(4'h8, d); chk(d[31] == 1, "R11 running bit", d[31], 1);

    // R5 / R6 sweep of divider codes and reloads
    for (int dv = 0; dv < 4; dv++) begin
      for (int k = 0; k < 6; k++) begin
        unlock_pair(1, 0, dv[1:0], rls[k]);
        exp_n = (1 << dv) * ((rls[k] == 0) ? 1 : int'(rls[k]));
        measure(400, n);
        chk(n == exp_n, $sformatf("R5 expiry div=%0d rl=%0d", dv, rls[k]), n, exp_n);
        @(negedge clk);
        chk(!wdt_rst_req, "R6 pulse one cycle", wdt_rst_req, 0);
      end
    end
    // R6 no second request while waiting at zero
    measure(40, n); chk(n == 0, "R6 no repeat", n, 0);

    // R7 sticky flag and write-one-to-clear
    rd(4'h8, d); chk(d[0] == 1, "R7 flag set", d[0], 1);
    wr(4'h8, 32'h0);
    rd(4'h8, d); chk(d[0] == 1, "R7 write 0 keeps", d[0], 1);
    wr(4'h8, 32'h1);
    rd(4'h8, d); chk(d[0] == 0, "R7 write 1 clears", d[0], 0);

    // R8 service restarts the count
    unlock_pair(1, 0, 2'd1, 16'd20);
    measure(15, n); chk(n == 0, "R8 no early expiry", n, 0);
    unlock_pair(1, 0, 2'd1, 16'd20);
    measure(100, n); chk(n == 40, "R8 expiry after service", n, 40);

    // R9 disable stops the counter
    unlock_pair(1, 0, 2'd0, 16'd30);
    unlock_pair(0, 0, 2'd0, 16'd30);
    rd(4'h8, d); chk(d[31] == 0, "R9 stopped", d[31], 0);
    measure(100, n); chk(n == 0, "R9 no request", n, 0);

    // R10 lock prevents disable until reset
    unlock_pair(1, 1, 2'd0, 16'd60);
    unlock_pair(0, 0, 2'd0, 16'd60);
    rd(4'h8, d); chk(d[31] == 1, "R10 still running", d[31], 1);
    rd(4'h0, d); chk(d[30] == 1, "R10 lock kept", d[30], 1);
    do_reset();
    rd(4'h8, d); chk(d[31] == 0, "R10 reset releases", d[31], 0);
    rd(4'h0, d); chk(d == 0, "R1 ctrl after second reset", d, 0);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule